// File: doc/BRIEF.md
# Cascaded Image Sensor Readout Sequencer

This block holds the digital sequencing for one die of a linear image sensor that is chained with other dies in a scan module. Every die shares a scan clock and a global start line. All of its state changes on the falling clock edge. A strap input marks the first die in the chain. That die turns a global start into a fixed preprocessing wait and then steps through its pixels. A die further down the chain uses the global start only to arm itself. It begins stepping when the end-of-scan pulse of the die before it reaches its serial start input.

Each scan clock carries two pixel slots, one in each clock phase. The block therefore reports one pixel pair per clock: a valid strobe plus the index of the even slot of the pair. After the last pair it raises an end-of-scan pulse for one clock, and that pulse feeds the next die. Each start input goes through a one-shot edge guard, so a pulse held high across several falling edges still loads only one start token.

Top module: `cis_readout_seq`

## Requirements
- R1: While rst_n is low, and at once when it falls (even in the middle of a scan), pix_valid, scan_end and pix_index are all 0. They stay 0 until a scan starts.
- R2: A start input held high across many falling edges loads exactly one token. Holding gstart high through and past a full scan produces a single scan and no second one.
- R3: With first_die = 1, suppose gstart is low at one falling edge and high at the next (edge E0). pix_valid then stays 0 after edges E0 through E54 (55 clocks of preprocessing) and first goes high after edge E55.
- R4: Each clock of pix_valid carries two pixel slots. pix_index gives the even slot 2k for the k-th pair (k = 0 .. NUM_PIXELS/2 - 1), and pix_valid stays high for exactly NUM_PIXELS/2 consecutive clocks.
- R5: scan_end is high for exactly the one clock after the last pair, with pix_valid low during that clock. All outputs are 0 in the clock after that.
- R6: With first_die = 0, a gstart token arms the die but produces no output. A chain_in token sampled at a falling edge while the die is armed starts the pairs right after that same edge, with no preprocessing.
- R7: With first_die = 0, a chain_in pulse while the die is not armed (no gstart since reset or since the last scan) has no effect on any output.
- R8: With first_die = 1, chain_in has no effect on any output.
- R9: A gstart token that arrives during preprocessing or while pixels are being stepped is ignored. The scan keeps its normal length and does not restart afterwards.
- R10: The first pair of every scan has pix_index = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| gstart | input | 1 | Global start shared by all dies in the chain |
| chain_in | input | 1 | Serial start input, driven by the previous die's scan_end |
| first_die | input | 1 | Strap: 1 marks the first die and enables the preprocessing wait |
| pix_valid | output | 1 | High for each clock that carries an active pixel pair |
| pix_index | output | $clog2(NUM_PIXELS) | Even slot index of the current pair, 0 when idle |
| scan_end | output | 1 | One-clock end-of-scan pulse toward the next die |

## Verification
A preprocessing counter that is wrong by even one count moves the first pair away from the 56th falling edge, so a cycle-exact check on the first die catches it within about 56 clocks of the start. Damage to the pair counter shows up within one clock as a pix_index that does not advance by two, or as a scan_end that arrives early or late against NUM_PIXELS/2. A broken edge guard or a missing busy interlock shows only after the scan ends, as a second scan with no fresh start. The bench therefore watches the ports idle for longer than a preprocessing window after each scan.

// File: rtl/cis_seq_pkg.sv
package cis_seq_pkg;

  // Sequencer states: idle, armed (waiting on chain input), preprocessing,
  // stepping pixel pairs, end-of-scan pulse.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ARMED  = 3'd1,
    ST_PRE    = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_END    = 3'd4
  } seq_state_e;

  // Two pixel slots per scan clock.
  function automatic int unsigned pair_count(int unsigned n_pix);
    return n_pix / 2;
  endfunction

  // Even slot index carried by pair number k.
  function automatic int unsigned pair_to_slot(int unsigned k);
    return k * 2;
  endfunction

  // Falling-edge number (token edge = 0) after which the first pair shows.
  function automatic int unsigned first_pair_edge(int unsigned pre_cycles,
                                                  logic with_pre);
    return with_pre ? pre_cycles : 0;
  endfunction

endpackage

// File: rtl/seq_edge_capture.sv
// One-shot start guard: a level held over several falling edges yields a
// single token, on the first edge at which it is seen high.
module seq_edge_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic token_o
);

  logic seen_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= level_i;
  end

  assign token_o = level_i & ~seen_q;

endmodule

// File: rtl/seq_pre_timer.sv
// Counts the preprocessing clocks while run_i is high.
module seq_pre_timer #(
  parameter int PRE_CYCLES = 55,
  parameter int PRE_W      = $clog2(PRE_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  output logic             done_o,
  output logic [PRE_W-1:0] count_o
);

  localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE_CYCLES - 1);

  logic [PRE_W-1:0] cnt_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o  = run_i && (cnt_q == LAST);
  assign count_o = cnt_q;

endmodule

// File: rtl/seq_pair_stepper.sv
// Steps pixel pairs, one per scan clock, while run_i is high.
module seq_pair_stepper
  import cis_seq_pkg::*;
#(
  parameter int NUM_PIXELS = 64,
  parameter int IDX_W      = $clog2(NUM_PIXELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  output logic             last_o,
  output logic [IDX_W-1:0] index_o
);

  localparam int PAIRS  = int'(pair_count(NUM_PIXELS));
  localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic [PAIR_W-1:0] pair_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)               pair_q <= '0;
    else if (!run_i || last_o) pair_q <= '0;
    else                       pair_q <= pair_q + 1'b1;
  end

  assign last_o  = run_i && (pair_q == PAIR_W'(PAIRS - 1));
  assign index_o = run_i ? IDX_W'(pair_to_slot(int'(pair_q))) : '0;

endmodule

// File: rtl/cis_readout_seq.sv
module cis_readout_seq
  import cis_seq_pkg::*;
#(
  parameter int NUM_PIXELS = 64,
  parameter int PRE_CYCLES = 55
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          gstart,
  input  logic                          chain_in,
  input  logic                          first_die,
  output logic                          pix_valid,
  output logic [$clog2(NUM_PIXELS)-1:0] pix_index,
  output logic                          scan_end
);

  localparam int IDX_W     = $clog2(NUM_PIXELS);
  localparam int PRE_W     = $clog2(PRE_CYCLES);
  localparam int LAST_SLOT = NUM_PIXELS - 2;

  // Named internal events for the assertions.
  logic             gs_tok;
  logic             ch_tok;
  logic             pre_done;
  logic [PRE_W-1:0] pre_cnt;
  logic             last_pair;
  seq_state_e       state_q, state_d;

  // One-shot guards for both start inputs.
  logic [1:0] start_lv;
  logic [1:0] start_tok;
  assign start_lv = {chain_in, gstart};

  for (genvar g = 0; g < 2; g++) begin : g_guard
    seq_edge_capture u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (start_lv[g]),
      .token_o (start_tok[g])
    );
  end

  assign gs_tok = start_tok[0];
  assign ch_tok = start_tok[1];

  seq_pre_timer #(.PRE_CYCLES(PRE_CYCLES), .PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (state_q == ST_PRE),
    .done_o  (pre_done),
    .count_o (pre_cnt)
  );

  seq_pair_stepper #(.NUM_PIXELS(NUM_PIXELS), .IDX_W(IDX_W)) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (state_q == ST_ACTIVE),
    .last_o  (last_pair),
    .index_o (pix_index)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (gs_tok)    state_d = first_die ? ST_PRE : ST_ARMED;
      ST_ARMED:  if (ch_tok)    state_d = ST_ACTIVE;
      ST_PRE:    if (pre_done)  state_d = ST_ACTIVE;
      ST_ACTIVE: if (last_pair) state_d = ST_END;
      ST_END:                   state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign pix_valid = (state_q == ST_ACTIVE);
  assign scan_end  = (state_q == ST_END);

  // First die: the first pair follows a full preprocessing count.
  assert_pre_length_R3: assert property (@(negedge clk) disable iff (!rst_n)
    ($rose(pix_valid) && first_die) |-> ($past(pre_cnt) == PRE_W'(PRE_CYCLES - 1)));

  // Pair index steps by two slots per clock.
  assert_index_step_R4: assert property (@(negedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid)) |-> (pix_index == $past(pix_index) + IDX_W'(2)));

  // End pulse follows the last pair and lasts one clock.
  assert_end_after_last_R5: assert property (@(negedge clk) disable iff (!rst_n)
    scan_end |-> ($past(pix_valid) && ($past(pix_index) == IDX_W'(LAST_SLOT))));

  assert_end_single_R5: assert property (@(negedge clk) disable iff (!rst_n)
    scan_end |=> !scan_end);

  // Chained die starts only from the armed state.
  assert_chain_start_R6: assert property (@(negedge clk) disable iff (!rst_n)
    ($rose(pix_valid) && !first_die) |-> ($past(state_q) == ST_ARMED));

  // Every scan starts at slot zero.
  assert_first_index_R10: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> (pix_index == '0));

endmodule

// File: tb/cis_readout_seq_bench.sv
module cis_readout_seq_bench;

  localparam int PERIOD = 10;
  localparam int NPIX   = 64;
  localparam int PRE    = 55;
  localparam int PAIRS  = NPIX / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gstart = 1'b0;
  logic chain_in = 1'b0;
  logic first_die = 1'b1;
  logic pix_valid;
  logic [$clog2(NPIX)-1:0] pix_index;
  logic scan_end;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  cis_readout_seq #(.NUM_PIXELS(NPIX), .PRE_CYCLES(PRE)) u_cis_readout_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .gstart    (gstart),
    .chain_in  (chain_in),
    .first_die (first_die),
    .pix_valid (pix_valid),
    .pix_index (pix_index),
    .scan_end  (scan_end)
  );

  // Advance past one falling edge and settle away from it.
  task automatic fall();
    @(negedge clk);
    #(PERIOD/4);
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic expect_outs(input string tag, input int v, input int idx, input int e);
    chk(tag, "pix_valid", int'(pix_valid), v);
    chk(tag, "pix_index", int'(pix_index), idx);
    chk(tag, "scan_end", int'(scan_end), e);
  endtask

  task automatic idle_check(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      fall();
      expect_outs(tag, 0, 0, 0);
    end
  endtask

  // Called right after the token edge (c = 0). off = edge of the first pair.
  // inj_a / inj_b: clocks at which a gstart pulse is injected (-1 = none).
  task automatic observe_scan(input int off, input string tag_first,
                              input int inj_a, input int inj_b);
    for (int c = 0; c <= off + PAIRS + 1; c++) begin
      if (c > 0) fall();
      if (c < off)
        expect_outs("R3", 0, 0, 0);
      else if (c == off) begin
        chk(tag_first, "first pair valid", int'(pix_valid), 1);
        chk("R10", "first pair index", int'(pix_index), 0);
        chk(tag_first, "scan_end", int'(scan_end), 0);
      end else if (c < off + PAIRS)
        expect_outs("R4", 1, 2 * (c - off), 0);
      else if (c == off + PAIRS)
        expect_outs("R5", 0, 0, 1);
      else
        expect_outs("R5", 0, 0, 0);
      if (inj_a >= 0) gstart = (c == inj_a) || (c == inj_b);
    end
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0;
    gstart = 1'b0;
    chain_in = 1'b0;
    first_die = strap;
    fall();
    fall();
    expect_outs("R1", 0, 0, 0);
    rst_n = 1'b1;
    fall();
    expect_outs("R1", 0, 0, 0);
  endtask

  task automatic t_first_basic();
    do_reset(1'b1);
    gstart = 1'b1;
    fall();
    gstart = 1'b0;
    observe_scan(PRE, "R3", -1, -1);
    idle_check(5, "R2");
  endtask

  task automatic t_hold_start();
    do_reset(1'b1);
    gstart = 1'b1;
    fall();
    observe_scan(PRE, "R3", -1, -1);
    // gstart still high: no second token (R2)
    idle_check(PRE + 15, "R2");
    gstart = 1'b0;
    idle_check(2, "R2");
  endtask

  task automatic t_busy_ignore();
    do_reset(1'b1);
    gstart = 1'b1;
    fall();
    gstart = 1'b0;
    // one pulse during preprocessing, one during pair stepping (R9)
    observe_scan(PRE, "R3", 20, PRE + 10);
    gstart = 1'b0;
    idle_check(PRE + 15, "R9");
    // a fresh start afterwards is accepted and restarts at slot 0 (R10)
    gstart = 1'b1;
    fall();
    gstart = 1'b0;
    observe_scan(PRE, "R10", -1, -1);
  endtask

  task automatic t_first_ignores_chain();
    do_reset(1'b1);
    chain_in = 1'b1;
    fall();
    chain_in = 1'b0;
    idle_check(PRE + 10, "R8");
  endtask

  task automatic t_chain_die();
    do_reset(1'b0);
    gstart = 1'b1;
    fall();
    gstart = 1'b0;
    idle_check(PRE + 10, "R6");
    chain_in = 1'b1;
    fall();
    // chain_in held high through the scan: single token (R2)
    observe_scan(0, "R6", -1, -1);
    idle_check(5, "R2");
    chain_in = 1'b0;
    idle_check(2, "R6");
    // second armed scan starts again at slot 0 (R10)
    gstart = 1'b1;
    fall();
    gstart = 1'b0;
    idle_check(3, "R6");
    chain_in = 1'b1;
    fall();
    chain_in = 1'b0;
    observe_scan(0, "R10", -1, -1);
    // after the scan the die is no longer armed (R7)
    chain_in = 1'b1;
    fall();
    chain_in = 1'b0;
    expect_outs("R7", 0, 0, 0);
    idle_check(5, "R7");
  endtask

  task automatic t_chain_unarmed();
    do_reset(1'b0);
    chain_in = 1'b1;
    fall();
    chain_in = 1'b0;
    expect_outs("R7", 0, 0, 0);
    idle_check(10, "R7");
  endtask

  task automatic t_reset_mid();
    do_reset(1'b1);
    gstart = 1'b1;
    fall();
    gstart = 1'b0;
    for (int i = 0; i < PRE + 5; i++) fall();
    expect_outs("R4", 1, 10, 0);
    rst_n = 1'b0;
    #1;
    expect_outs("R1", 0, 0, 0);
    fall();
    expect_outs("R1", 0, 0, 0);
    rst_n = 1'b1;
    idle_check(3, "R1");
    gstart = 1'b1;
    fall();
    gstart = 1'b0;
    observe_scan(PRE, "R10", -1, -1);
  endtask

  initial begin
    t_first_basic();
    t_hold_start();
    t_busy_ignore();
    t_first_ignores_chain();
    t_chain_die();
    t_chain_unarmed();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule